// File: doc/BRIEF.md
# Flash Command Sequencer

This block interprets command writes for a byte-wide flash memory controller. Bus write cycles reach it already sampled, each as a single-cycle valid strobe with a 19-bit address and a data byte. The block recognises two-write setup/execute pairs for byte program, sector erase and chip erase. It also recognises a one-write abort code and a one-write entry into identification mode. When an execute write completes a valid pair, the block sends a one-cycle start pulse to the array-operation timer, together with the address and data that the operation must use.

The block also tells the read path which source to return: the array, the identification bytes or operation status. A protect flag from a separate detector blocks all array-modifying operations. A busy flag from the operation timer makes the block ignore command writes while an operation is running.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read mode: no start pulse is high, and rd_sel_o is 0 (array).
- R2: A write of 10h followed by any second write whose data is not FFh raises start_prog_o for exactly one cycle, in the cycle after the second write. op_addr_o then holds that write's full address and op_data_o holds its data.
- R3: A write of 20h followed by a write of D0h raises start_sector_erase_o for one cycle, in the cycle after the D0h write. op_addr_o holds bits [18:8] of the D0h write's address with bits [7:0] cleared, and op_data_o is FFh.
- R4: A write of 30h followed by a second write of 30h raises start_chip_erase_o for one cycle. op_addr_o is 0 and op_data_o is FFh, whatever addresses were written.
- R5: A write of FFh while a setup is pending cancels it: no start pulse, and the block is back in read mode.
- R6: A second write that does not carry its command's execute code (D0h for 20h, 30h for 30h) drops the sequence without any start pulse, and the block returns to read mode.
- R7: A write of 90h enters identification mode, where rd_sel_o is 1. Unrecognised data codes leave that mode unchanged. Writes of FFh, 10h, 20h or 30h leave it.
- R8: While protect_i is high, writes of 10h, 20h and 30h are ignored, and an execute write ends its pending sequence without a start pulse. FFh and 90h are still obeyed.
- R9: While busy_i is high, every write is ignored, and rd_sel_o is 2 (status).
- R10: At most one start pulse is high in any cycle, and no start pulse lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | One sampled command write this cycle |
| wr_addr_i | input | 19 | Address of the write |
| wr_data_i | input | 8 | Data byte of the write |
| protect_i | input | 1 | Software protection active |
| busy_i | input | 1 | Array operation in progress |
| start_prog_o | output | 1 | One-cycle byte program start |
| start_sector_erase_o | output | 1 | One-cycle sector erase start |
| start_chip_erase_o | output | 1 | One-cycle chip erase start |
| op_addr_o | output | 19 | Address for the started operation |
| op_data_o | output | 8 | Data for the started operation |
| rd_sel_o | output | 2 | Read source: 0 array, 1 ID, 2 status |

## Verification
The assertions check on every cycle that start pulses are mutually exclusive and last one cycle. They also check that no pulse follows a write made under protection or busy, or a cycle with no write, that busy freezes the command state, and that erase addresses are aligned or zero. The bench's scenarios are what show the sequences themselves: which second writes start, abort or drop an operation, how identification mode is entered and left, and that protection still lets abort and identification through. A behavioural model compares every output on every clock.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CODE_PROG    = 8'h10;
  localparam logic [7:0] CODE_SERASE  = 8'h20;
  localparam logic [7:0] CODE_CERASE  = 8'h30;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_ABORT   = 8'hFF;
  localparam logic [7:0] CODE_IDENT   = 8'h90;

  typedef enum logic [2:0] {
    CMD_OTHER, CMD_PROG, CMD_SERASE, CMD_CERASE, CMD_CONFIRM, CMD_ABORT, CMD_IDENT
  } cmd_e;

  typedef enum logic [2:0] {
    MODE_READ, MODE_IDENT, MODE_PROG_SU, MODE_SERASE_SU, MODE_CERASE_SU
  } mode_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_PROG, OP_SERASE, OP_CERASE
  } op_e;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0, RD_IDENT = 2'd1, RD_STATUS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output cmd_e              cmd_o
);
  always_comb begin
    unique case (data_i[7:0])
      CODE_PROG:    cmd_o = CMD_PROG;
      CODE_SERASE:  cmd_o = CMD_SERASE;
      CODE_CERASE:  cmd_o = CMD_CERASE;
      CODE_CONFIRM: cmd_o = CMD_CONFIRM;
      CODE_ABORT:   cmd_o = CMD_ABORT;
      CODE_IDENT:   cmd_o = CMD_IDENT;
      default:      cmd_o = CMD_OTHER;
    endcase
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_valid_i,
  input  logic  busy_i,
  input  logic  protect_i,
  input  cmd_e  cmd_i,
  output mode_e mode_o,
  output op_e   fire_o
);
  mode_e mode_q, mode_d;
  logic  accept;

  assign accept = wr_valid_i & ~busy_i;

  always_comb begin
    mode_d = mode_q;
    fire_o = OP_NONE;
    if (accept) begin
      unique case (mode_q)
        MODE_READ, MODE_IDENT: begin
          unique case (cmd_i)
            CMD_ABORT:  mode_d = MODE_READ;
            CMD_IDENT:  mode_d = MODE_IDENT;
            CMD_PROG:   if (!protect_i) mode_d = MODE_PROG_SU;
            CMD_SERASE: if (!protect_i) mode_d = MODE_SERASE_SU;
            CMD_CERASE: if (!protect_i) mode_d = MODE_CERASE_SU;
            default:    mode_d = mode_q;
          endcase
        end
        MODE_PROG_SU: begin
          mode_d = MODE_READ;
          if (cmd_i != CMD_ABORT && !protect_i) fire_o = OP_PROG;
        end
        MODE_SERASE_SU: begin
          mode_d = MODE_READ;
          if (cmd_i == CMD_CONFIRM && !protect_i) fire_o = OP_SERASE;
        end
        MODE_CERASE_SU: begin
          mode_d = MODE_READ;
          if (cmd_i == CMD_CERASE && !protect_i) fire_o = OP_CERASE;
        end
        default: mode_d = MODE_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_READ;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R9: command state frozen while the timer is busy
  assert_busy_holds_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(mode_q));
  // R5/R6: any accepted write in a setup state leaves setup
  assert_setup_single_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode_q inside {MODE_PROG_SU, MODE_SERASE_SU, MODE_CERASE_SU})
    |=> mode_q == MODE_READ);
endmodule

// File: rtl/flash_op_issue.sv
module flash_op_issue
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SECT_OFS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_prog_o,
  output logic              start_sector_erase_o,
  output logic              start_chip_erase_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);
  localparam int SECT_W = ADDR_W - SECT_OFS_W;
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  logic [ADDR_W-1:0] sect_base;
  assign sect_base = {addr_i[ADDR_W-1 -: SECT_W], {SECT_OFS_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_prog_o         <= 1'b0;
      start_sector_erase_o <= 1'b0;
      start_chip_erase_o   <= 1'b0;
      op_addr_o            <= '0;
      op_data_o            <= '0;
    end else begin
      start_prog_o         <= (fire_i == OP_PROG);
      start_sector_erase_o <= (fire_i == OP_SERASE);
      start_chip_erase_o   <= (fire_i == OP_CERASE);
      unique case (fire_i)
        OP_PROG:   begin op_addr_o <= addr_i;    op_data_o <= data_i; end
        OP_SERASE: begin op_addr_o <= sect_base; op_data_o <= ERASED; end
        OP_CERASE: begin op_addr_o <= '0;        op_data_o <= ERASED; end
        default: ;
      endcase
    end
  end

  assert_sector_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_sector_erase_o |-> op_addr_o[SECT_OFS_W-1:0] == '0);
  assert_chip_addr_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_chip_erase_o |-> (op_addr_o == '0 && op_data_o == ERASED));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SECT_OFS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              protect_i,
  input  logic              busy_i,
  output logic              start_prog_o,
  output logic              start_sector_erase_o,
  output logic              start_chip_erase_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        rd_sel_o
);
  cmd_e  cmd;
  mode_e mode;
  op_e   fire;

  flash_cmd_decode #(.DATA_W(DATA_W)) u_decode (
    .data_i (wr_data_i),
    .cmd_o  (cmd)
  );

  flash_cmd_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .busy_i     (busy_i),
    .protect_i  (protect_i),
    .cmd_i      (cmd),
    .mode_o     (mode),
    .fire_o     (fire)
  );

  flash_op_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_OFS_W(SECT_OFS_W)) u_issue (
    .clk_i                (clk_i),
    .rst_ni               (rst_ni),
    .fire_i               (fire),
    .addr_i               (wr_addr_i),
    .data_i               (wr_data_i),
    .start_prog_o         (start_prog_o),
    .start_sector_erase_o (start_sector_erase_o),
    .start_chip_erase_o   (start_chip_erase_o),
    .op_addr_o            (op_addr_o),
    .op_data_o            (op_data_o)
  );

  always_comb begin
    if (busy_i)                 rd_sel_o = RD_STATUS;
    else if (mode == MODE_IDENT) rd_sel_o = RD_IDENT;
    else                        rd_sel_o = RD_ARRAY;
  end

  logic any_start;
  assign any_start = start_prog_o | start_sector_erase_o | start_chip_erase_o;

  assert_one_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_prog_o, start_sector_erase_o, start_chip_erase_o}));
  assert_start_single_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_start |=> !any_start);
  assert_protect_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_i |=> !any_start);
  assert_busy_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !any_start);
  assert_start_needs_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !any_start);
endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        protect = 1'b0;
  logic        busy = 1'b0;
  logic        sp, sse, sce;
  logic [18:0] op_addr;
  logic [7:0]  op_data;
  logic [1:0]  rd_sel;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  flash_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .protect_i(protect), .busy_i(busy),
    .start_prog_o(sp), .start_sector_erase_o(sse), .start_chip_erase_o(sce),
    .op_addr_o(op_addr), .op_data_o(op_data), .rd_sel_o(rd_sel)
  );

  // reference model: 0 read, 1 ident, 2 prog pending, 3 sector pending, 4 chip pending
  int          m_mode = 0;
  bit          e_sp, e_sse, e_sce;
  logic [18:0] e_addr = '0;
  logic [7:0]  e_data = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; e_sp = 0; e_sse = 0; e_sce = 0; e_addr = '0; e_data = '0;
    end else begin
      e_sp = 0; e_sse = 0; e_sce = 0;
      if (wr_valid && !busy) begin
        if (m_mode >= 2) begin
          if (!protect && m_mode == 2 && wr_data != 8'hFF) begin
            e_sp = 1; e_addr = wr_addr; e_data = wr_data;
          end else if (!protect && m_mode == 3 && wr_data == 8'hD0) begin
            e_sse = 1; e_addr = wr_addr & 19'h7FF00; e_data = 8'hFF;
          end else if (!protect && m_mode == 4 && wr_data == 8'h30) begin
            e_sce = 1; e_addr = '0; e_data = 8'hFF;
          end
          m_mode = 0;
        end else begin
          case (wr_data)
            8'hFF: m_mode = 0;
            8'h90: m_mode = 1;
            8'h10: if (!protect) m_mode = 2;
            8'h20: if (!protect) m_mode = 3;
            8'h30: if (!protect) m_mode = 4;
            default: ;
          endcase
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    chk({phase, " start_prog (R2)"}, int'(sp), int'(e_sp));
    chk({phase, " start_sector_erase (R3)"}, int'(sse), int'(e_sse));
    chk({phase, " start_chip_erase (R4)"}, int'(sce), int'(e_sce));
    chk({phase, " rd_sel (R7/R9)"}, int'(rd_sel), busy ? 2 : (m_mode == 1 ? 1 : 0));
    if (e_sp || e_sse || e_sce) begin
      chk({phase, " op_addr"}, int'(op_addr), int'(e_addr));
      chk({phase, " op_data"}, int'(op_data), int'(e_data));
    end
  end

  task automatic wr(input logic [18:0] a, input logic [7:0] d, input int gap = 1);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = 19'h5555A; wr_data = 8'hA5;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(3);

    phase = "R2";
    wr(19'h12345, 8'h10);
    wr(19'h5A5A5, 8'h3C, 3);
    wr(19'h00001, 8'h10, 0);
    wr(19'h7FFFF, 8'h00, 2);

    phase = "R9";
    wr(19'h00000, 8'h10);
    @(negedge clk) busy = 1'b1;
    wr(19'h00010, 8'h77);
    wr(19'h00000, 8'h90);
    idle(2);
    @(negedge clk) busy = 1'b0;
    wr(19'h00020, 8'h66, 2);

    phase = "R3";
    wr(19'h00000, 8'h20);
    wr(19'h7ABCD, 8'hD0, 3);
    wr(19'h3FFFF, 8'h20, 0);
    wr(19'h000FF, 8'hD0, 2);

    phase = "R4";
    wr(19'h12345, 8'h30);
    wr(19'h6789A, 8'h30, 3);

    phase = "R5";
    wr(19'h0, 8'h10); wr(19'h100, 8'hFF, 2);
    wr(19'h0, 8'h20); wr(19'h100, 8'hFF, 2);
    wr(19'h0, 8'h30); wr(19'h100, 8'hFF, 2);

    phase = "R6";
    wr(19'h0, 8'h20); wr(19'h200, 8'h30, 2);
    wr(19'h0, 8'h30); wr(19'h200, 8'hD0, 2);
    wr(19'h0, 8'h20); wr(19'h200, 8'h20, 2);
    wr(19'h300, 8'hD0, 2);

    phase = "R7";
    wr(19'h0, 8'h90, 2);
    wr(19'h0, 8'h55, 2);
    wr(19'h0, 8'hFF, 2);
    wr(19'h0, 8'h90, 2);
    wr(19'h0, 8'h20);
    wr(19'h45612, 8'hD0, 2);
    wr(19'h0, 8'h90, 2);
    wr(19'h0, 8'h10);
    wr(19'h00042, 8'h81, 2);

    phase = "R8";
    @(negedge clk) protect = 1'b1;
    wr(19'h0, 8'h10); wr(19'h123, 8'h55, 2);
    wr(19'h0, 8'h20); wr(19'h123, 8'hD0, 2);
    wr(19'h0, 8'h30); wr(19'h123, 8'h30, 2);
    wr(19'h0, 8'h90, 2);
    wr(19'h0, 8'h20, 2);
    wr(19'h0, 8'hFF, 2);
    @(negedge clk) protect = 1'b0;
    wr(19'h0, 8'h20);
    @(negedge clk) protect = 1'b1;
    wr(19'h400, 8'hD0, 2);
    @(negedge clk) protect = 1'b0;
    wr(19'h500, 8'hD0, 2);

    phase = "R10";
    wr(19'h0, 8'h30, 0);
    wr(19'h0, 8'h30, 0);
    wr(19'h0, 8'h10, 0);
    wr(19'h0, 8'h10, 0);
    wr(19'h0, 8'h20, 0);
    wr(19'h0, 8'hD0, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule